// File: doc/BRIEF.md
# Processor Power State Controller

This block is a synchronous state machine that follows the low-power mode of a processor core. It moves between five modes: running, halted after a halt instruction, stop-granted on an external clock-stop request, snoop service while a bus snoop is handled, and deep sleep. The block drives an internal clock enable, a snoop-response enable, a flush acknowledge and one-shot service pulses for interrupt events that were held back while the core was stopped.

The machine records which mode it left on the way into stop-grant and into snoop service, so that it can return to that mode. Interrupt events that arrive during stop-grant are merged into one pending flag per source. Once the core runs again, the flags drain one per cycle in a fixed priority order. Requests that have no meaning in the current mode are ignored. A snoop that arrives during sleep sets a sticky error flag and does not change the mode.

Top module: `pwr_state_ctrl`

## Requirements
- R1: With `rst_ni` low, the block is at once in the running mode (`state_o`=0), with `clk_en_o`=1 and every other output 0.
- R2: `state_o` uses the codes running=0, halted=1, stop-grant=2, snoop service=3, sleep=4. `clk_en_o` is high only when the code is 0, and `snoop_resp_o` is high only when it is 3.
- R3: A `halt_i` strobe in the running mode moves to halted. A `wake_i` strobe in halted moves back to running.
- R4: A low `stop_req_ni` in running or in halted moves to stop-grant. In halted, stop takes priority over snoop and wake. When `stop_req_ni` goes high in stop-grant, the block returns to the mode it entered stop-grant from. This return takes priority over sleep and snoop.
- R5: A high `snoop_act_i` in halted or in stop-grant moves to snoop service. The block stays there until `snoop_done_i` is high, then returns to the mode it left. After a return to stop-grant, that mode still remembers its own origin.
- R6: A low `nap_req_ni` moves to sleep only from stop-grant. It has no effect in running or halted. When `nap_req_ni` goes high in sleep, the block returns to stop-grant.
- R7: In sleep, `clk_en_o` and `snoop_resp_o` stay low and the mode does not leave sleep while `nap_req_ni` is low. A snoop sets `snoop_err_o`, which stays high until `rst_ni`. Events that arrive in sleep are not latched.
- R8: A falling edge on `flush_req_ni` in halted produces a one-cycle `flush_ack_o` on the next cycle, and the mode stays halted. A flush request in stop-grant or in running gives no acknowledge.
- R9: A low `core_rst_ni` clears all pending event flags. In running, halted or snoop service it also forces the running mode. In stop-grant and in sleep the mode is kept.
- R10: In stop-grant only, a high bit of `evt_i` sets its pending flag. Repeats of the same event merge into one flag. Events in any other mode are ignored.
- R11: In the running mode, pending flags produce one-hot `svc_o` pulses, one per cycle. Each pulse is registered, so it appears one cycle after the flag is chosen. The order is bit 0 (SMI), bit 1 (INIT), bit 2 (LINT0), bit 3 (LINT1). Each flag pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_ni | input | 1 | Clock-stop request, active low |
| nap_req_ni | input | 1 | Sleep request, active low |
| flush_req_ni | input | 1 | Cache flush request, active low |
| core_rst_ni | input | 1 | Core context reset request, active low |
| halt_i | input | 1 | Halt instruction strobe |
| wake_i | input | 1 | Wake or interrupt indication |
| snoop_act_i | input | 1 | Bus snoop active |
| snoop_done_i | input | 1 | Bus snoop serviced |
| evt_i | input | NUM_EVT | Event inputs: bit0 SMI, bit1 INIT, bit2 LINT0, bit3 LINT1 |
| state_o | output | 3 | Current mode code |
| clk_en_o | output | 1 | Internal clock enable |
| flush_ack_o | output | 1 | Flush acknowledge pulse |
| snoop_resp_o | output | 1 | Snoop response enable |
| svc_o | output | NUM_EVT | One-hot event service pulse |
| snoop_err_o | output | 1 | Sticky error flag for a snoop during sleep |

## Verification
The assertions assume that `snoop_done_i` is only meaningful while a snoop is being served. They also assume that the sleep request is held and released cleanly around sleep. Apart from the snoop that is deliberately sent to test the error flag, no other input moves during sleep. The stimulus changes inputs only on falling edges. It asserts one request class at a time, except in the cases where priority is the point of the check. It sweeps every non-empty event mask from both stop-grant origins, and each mask is sent twice to exercise the merging of repeats.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN     = 3'd0,
    PS_HALT    = 3'd1,
    PS_STOPGNT = 3'd2,
    PS_SNOOP   = 3'd3,
    PS_SLEEP   = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_ni,
  input  logic       nap_req_ni,
  input  logic       core_rst_ni,
  input  logic       halt_i,
  input  logic       wake_i,
  input  logic       snoop_act_i,
  input  logic       snoop_done_i,
  output pwr_state_e state_o
);
  pwr_state_e state_q, state_d;
  logic sg_from_halt_q, sg_from_halt_d;  // stop-grant origin
  logic snp_from_halt_q, snp_from_halt_d; // snoop origin

  always_comb begin
    state_d         = state_q;
    sg_from_halt_d  = sg_from_halt_q;
    snp_from_halt_d = snp_from_halt_q;
    unique case (state_q)
      PS_RUN: begin
        if (!core_rst_ni)      state_d = PS_RUN;
        else if (!stop_req_ni) begin
          state_d        = PS_STOPGNT;
          sg_from_halt_d = 1'b0;
        end else if (halt_i)   state_d = PS_HALT;
      end
      PS_HALT: begin
        if (!core_rst_ni)      state_d = PS_RUN;
        else if (!stop_req_ni) begin
          state_d        = PS_STOPGNT;
          sg_from_halt_d = 1'b1;
        end else if (snoop_act_i) begin
          state_d         = PS_SNOOP;
          snp_from_halt_d = 1'b1;
        end else if (wake_i)   state_d = PS_RUN;
      end
      PS_STOPGNT: begin
        if (stop_req_ni)       state_d = sg_from_halt_q ? PS_HALT : PS_RUN;
        else if (!nap_req_ni)  state_d = PS_SLEEP;
        else if (snoop_act_i) begin
          state_d         = PS_SNOOP;
          snp_from_halt_d = 1'b0;
        end
      end
      PS_SNOOP: begin
        if (!core_rst_ni)      state_d = PS_RUN;
        else if (snoop_done_i) state_d = snp_from_halt_q ? PS_HALT : PS_STOPGNT;
      end
      PS_SLEEP: begin
        if (nap_req_ni)        state_d = PS_STOPGNT;
      end
      default:                 state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= PS_RUN;
      sg_from_halt_q  <= 1'b0;
      snp_from_halt_q <= 1'b0;
    end else begin
      state_q         <= state_d;
      sg_from_halt_q  <= sg_from_halt_d;
      snp_from_halt_q <= snp_from_halt_d;
    end
  end

  assign state_o = state_q;

  p_stop_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == PS_RUN || state_q == PS_HALT) && core_rst_ni && !stop_req_ni)
      |=> (state_q == PS_STOPGNT));

  p_snoop_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SNOOP && core_rst_ni && !snoop_done_i) |=> (state_q == PS_SNOOP));

  p_sleep_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PS_STOPGNT && state_q != PS_SLEEP) |=> (state_q != PS_SLEEP));

  p_sleep_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SLEEP && !nap_req_ni) |=> (state_q == PS_SLEEP));

  p_sg_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_STOPGNT && !stop_req_ni && nap_req_ni && !snoop_act_i)
      |=> (state_q == PS_STOPGNT));
endmodule

// File: rtl/pwr_evt_pend.sv
module pwr_evt_pend #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               core_rst_ni,
  input  logic               latch_en_i,
  input  logic               drain_en_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_EVT-1:0] svc_o
);
  logic [NUM_EVT-1:0] pend_q, pend_d, grant, lower_busy;
  logic [NUM_EVT-1:0] svc_q;

  // lowest index wins
  assign lower_busy[0] = 1'b0;
  assign grant[0]      = pend_q[0];
  for (genvar i = 1; i < NUM_EVT; i++) begin : g_prio
    assign lower_busy[i] = lower_busy[i-1] | pend_q[i-1];
    assign grant[i]      = pend_q[i] & ~lower_busy[i];
  end

  always_comb begin
    if (!core_rst_ni)     pend_d = '0;
    else if (latch_en_i)  pend_d = pend_q | evt_i;
    else if (drain_en_i)  pend_d = pend_q & ~grant;
    else                  pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= (core_rst_ni && drain_en_i) ? grant : '0;
    end
  end

  assign svc_o = svc_q;

  p_svc_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_o));

  p_svc_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|svc_o) |-> ((pend_q & svc_o) == '0));

  p_no_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_en_i) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/pwr_side_ctrl.sv
module pwr_side_ctrl
  import pwr_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_state_e state_i,
  input  logic       flush_req_ni,
  input  logic       snoop_act_i,
  output logic       flush_ack_o,
  output logic       snoop_err_o
);
  logic flush_n_q, ack_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_n_q <= 1'b1;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      flush_n_q <= flush_req_ni;
      ack_q     <= (state_i == PS_HALT) && !flush_req_ni && flush_n_q;
      err_q     <= err_q | ((state_i == PS_SLEEP) && snoop_act_i);
    end
  end

  assign flush_ack_o = ack_q;
  assign snoop_err_o = err_q;

  p_flush_in_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ack_o |-> ($past(state_i) == PS_HALT));

  p_flush_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ack_o |=> !flush_ack_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_err_o |=> snoop_err_o);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_req_ni,
  input  logic               nap_req_ni,
  input  logic               flush_req_ni,
  input  logic               core_rst_ni,
  input  logic               halt_i,
  input  logic               wake_i,
  input  logic               snoop_act_i,
  input  logic               snoop_done_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [STATE_W-1:0] state_o,
  output logic               clk_en_o,
  output logic               flush_ack_o,
  output logic               snoop_resp_o,
  output logic [NUM_EVT-1:0] svc_o,
  output logic               snoop_err_o
);
  pwr_state_e state;

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_req_ni  (stop_req_ni),
    .nap_req_ni   (nap_req_ni),
    .core_rst_ni  (core_rst_ni),
    .halt_i       (halt_i),
    .wake_i       (wake_i),
    .snoop_act_i  (snoop_act_i),
    .snoop_done_i (snoop_done_i),
    .state_o      (state)
  );

  pwr_evt_pend #(.NUM_EVT(NUM_EVT)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_rst_ni (core_rst_ni),
    .latch_en_i  (state == PS_STOPGNT),
    .drain_en_i  (state == PS_RUN),
    .evt_i       (evt_i),
    .svc_o       (svc_o)
  );

  pwr_side_ctrl u_side (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .flush_req_ni (flush_req_ni),
    .snoop_act_i  (snoop_act_i),
    .flush_ack_o  (flush_ack_o),
    .snoop_err_o  (snoop_err_o)
  );

  assign state_o      = state;
  assign clk_en_o     = (state == PS_RUN);
  assign snoop_resp_o = (state == PS_SNOOP);

  p_svc_in_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|svc_o) |-> ($past(state_o) == 3'd0));
endmodule

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
  logic clk_i = 1'b0;
  logic rst_ni, stop_req_ni, nap_req_ni, flush_req_ni, core_rst_ni;
  logic halt_i, wake_i, snoop_act_i, snoop_done_i;
  logic [3:0] evt_i;
  logic [2:0] state_o;
  logic clk_en_o, flush_ack_o, snoop_resp_o, snoop_err_o;
  logic [3:0] svc_o;
  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  pwr_state_ctrl #(.NUM_EVT(4)) uut (
    .clk_i, .rst_ni, .stop_req_ni, .nap_req_ni, .flush_req_ni, .core_rst_ni,
    .halt_i, .wake_i, .snoop_act_i, .snoop_done_i, .evt_i,
    .state_o, .clk_en_o, .flush_ack_o, .snoop_resp_o, .svc_o, .snoop_err_o
  );

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 0; stop_req_ni = 1; nap_req_ni = 1; flush_req_ni = 1; core_rst_ni = 1;
    halt_i = 0; wake_i = 0; snoop_act_i = 0; snoop_done_i = 0; evt_i = '0;
    #5;
    chk("R1 state", state_o, 0);
    chk("R1 clk_en", clk_en_o, 1);
    chk("R1 others", {flush_ack_o, snoop_resp_o, snoop_err_o, svc_o}, 0);
    step(); rst_ni = 1; step();

    // R3 halt / wake
    halt_i = 1; step(); halt_i = 0;
    chk("R3 halt", state_o, 1);
    chk("R2 clk_en off in halt", clk_en_o, 0);
    wake_i = 1; step(); wake_i = 0;
    chk("R3 wake", state_o, 0);

    // R6 sleep request ignored in running and halted
    nap_req_ni = 0; step();
    chk("R6 nap ignored run", state_o, 0);
    nap_req_ni = 1; halt_i = 1; step(); halt_i = 0;
    nap_req_ni = 0; step();
    chk("R6 nap ignored halt", state_o, 1);
    nap_req_ni = 1;

    // R8 flush in halted
    flush_req_ni = 0; step();
    chk("R8 flush ack", flush_ack_o, 1);
    chk("R8 stays halted", state_o, 1);
    step();
    chk("R8 single pulse", flush_ack_o, 0);
    flush_req_ni = 1; step();

    // R4 stop from halted, R8 flush ignored in stop-grant
    stop_req_ni = 0; step();
    chk("R4 halt->stopgnt", state_o, 2);
    chk("R2 clk_en off stopgnt", clk_en_o, 0);
    flush_req_ni = 0; step();
    chk("R8 no ack in stopgnt", flush_ack_o, 0);
    flush_req_ni = 1; stop_req_ni = 1; step();
    chk("R4 return to halted", state_o, 1);
    wake_i = 1; step(); wake_i = 0;
    flush_req_ni = 0; step();
    chk("R8 no ack in run", flush_ack_o, 0);
    flush_req_ni = 1;
    stop_req_ni = 0; step();
    chk("R4 run->stopgnt", state_o, 2);
    stop_req_ni = 1; step();
    chk("R4 return to run", state_o, 0);

    // R5 snoop from stop-grant (origin run) and from halted
    stop_req_ni = 0; step();
    snoop_act_i = 1; step(); snoop_act_i = 0;
    chk("R5 enter snoop", state_o, 3);
    chk("R2 snoop_resp", snoop_resp_o, 1);
    step();
    chk("R5 hold snoop", state_o, 3);
    snoop_done_i = 1; step(); snoop_done_i = 0;
    chk("R5 back to stopgnt", state_o, 2);
    chk("R2 snoop_resp off", snoop_resp_o, 0);
    stop_req_ni = 1; step();
    chk("R5 origin kept run", state_o, 0);
    halt_i = 1; step(); halt_i = 0;
    snoop_act_i = 1; step(); snoop_act_i = 0;
    chk("R5 halt->snoop", state_o, 3);
    snoop_done_i = 1; step(); snoop_done_i = 0;
    chk("R5 back to halted", state_o, 1);
    // R4 priority: stop beats snoop and wake in halted
    stop_req_ni = 0; snoop_act_i = 1; wake_i = 1; step();
    snoop_act_i = 0; wake_i = 0;
    chk("R4 stop priority", state_o, 2);
    snoop_act_i = 1; step(); snoop_act_i = 0;
    snoop_done_i = 1; step(); snoop_done_i = 0;
    stop_req_ni = 1; step();
    chk("R5 stopgnt origin halted kept", state_o, 1);
    wake_i = 1; step(); wake_i = 0;

    // R6/R7 sleep
    stop_req_ni = 0; step();
    nap_req_ni = 0; step();
    chk("R6 enter sleep", state_o, 4);
    chk("R7 clk off sleep", clk_en_o, 0);
    snoop_act_i = 1; evt_i = 4'hF; step(); snoop_act_i = 0; evt_i = '0;
    chk("R7 snoop ignored", state_o, 4);
    chk("R7 no snoop resp", snoop_resp_o, 0);
    chk("R7 err set", snoop_err_o, 1);
    nap_req_ni = 1; step();
    chk("R6 sleep->stopgnt", state_o, 2);
    stop_req_ni = 1; step();
    chk("R4 back to run", state_o, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 sleep events not latched", svc_o, 0);
    end
    chk("R7 err sticky", snoop_err_o, 1);

    // R9 core reset
    halt_i = 1; step(); halt_i = 0;
    core_rst_ni = 0; step(); core_rst_ni = 1;
    chk("R9 halt->run", state_o, 0);
    stop_req_ni = 0; step();
    evt_i = 4'b0101; step(); evt_i = '0;
    core_rst_ni = 0; step(); core_rst_ni = 1;
    chk("R9 stays stopgnt", state_o, 2);
    stop_req_ni = 1; step();
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 pending cleared", svc_o, 0);
    end

    // R10 events in run ignored
    evt_i = 4'hF; step(); evt_i = '0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10 run events ignored", svc_o, 0);
    end

    // R10/R11 sweep of masks and origins
    for (int org = 0; org < 2; org++) begin
      for (int m = 1; m < 16; m++) begin
        int rem;
        if (org == 1) begin halt_i = 1; step(); halt_i = 0; end
        stop_req_ni = 0; step();
        evt_i = m[3:0]; step(); evt_i = '0; step();
        evt_i = m[3:0]; step(); evt_i = '0;
        stop_req_ni = 1; step();
        chk("R4 sweep return", state_o, org);
        chk("R11 no svc on entry", svc_o, 0);
        if (org == 1) begin
          wake_i = 1; step(); wake_i = 0;
          chk("R11 no svc in halted", svc_o, 0);
        end
        rem = m;
        while (rem != 0) begin
          step();
          chk("R11 svc order", svc_o, rem & -rem);
          rem = rem & (rem - 1);
        end
        step();
        chk("R10 coalesced once", svc_o, 0);
      end
    end

    summary();
  end
endmodule